// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a target on a two-wire (I2C-compatible) bus that fronts a small byte-wide memory held in registers. SCL and SDA arrive as plain inputs and are oversampled by the system clock. SDA is driven through an open-drain enable: the block can only pull the line low or let it go. Three strap inputs set the low bits of the bus address, so up to eight copies can share one bus.

A host stores bytes with a one-byte write or a write of up to eight bytes into one page. The bytes collect in a page buffer. On STOP they are committed to the array together. A self-timed busy period follows, and during it the block ignores its own address. A write-protect input keeps the array untouched. The host reads bytes back in three ways: from the internal pointer, from an address it has just set (a dummy write followed by a repeated START), or as a sequential stream that keeps going for as long as the host acknowledges each byte.

Top module: `seeprom_target`

## Requirements
- R1: The block acknowledges a bus address byte only when its upper seven bits equal binary 1010 followed by strap_i[2:0] (strap_i[2] first). Bit 0 of that byte selects read (1) or write (0). For any other address it leaves SDA released for the acknowledge bit.
- R2: sda_oe_o high means SDA is pulled low. An acknowledge is asserted after the SCL falling edge that ends the eighth bit of a byte. On a write it is released after the next SCL falling edge, and it is never asserted while the block is idle.
- R3: After reset, sda_oe_o is low, every word reads 0xFF and the internal pointer is 0.
- R4: Data bytes that follow the word address are committed to the array only when a STOP arrives. Every data byte gets an acknowledge.
- R5: During a write, the low three address bits step up and wrap inside the current 8-word page, and the upper bits stay fixed. A ninth byte therefore overwrites the word that the first byte wrote.
- R6: A write of fewer than 8 bytes changes only the words it addressed, and the other words of the page keep their values.
- R7: After a commit, the block does not acknowledge its address for WRITE_CYCLES clock cycles. Once that period ends, it acknowledges again.
- R8: While wp_i is high, data bytes are still acknowledged, but nothing is committed and no busy period starts.
- R9: A read without a word address starts at the internal pointer. The pointer holds the word after the last one read. After a write, it holds the page-wrapped address that follows the last data byte.
- R10: A dummy write of a word address, then a repeated START and a read address, returns data starting at that word address.
- R11: A read returns successive words for as long as the host acknowledges. After word DEPTH-1 it continues at word 0. A host non-acknowledge ends the read.
- R12: Read data goes out MSB first. It changes only after an SCL falling edge and is held stable while SCL is high.
- R13: A repeated START before STOP throws away the data bytes already received, so the array is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Low three bits of the bus address |
| wp_i | input | 1 | Write protect, high blocks commits |
| sda_oe_o | output | 1 | High pulls SDA low |

## Verification
Each bus edge takes two synchronizer stages and one edge-detect register to reach the control logic, so sda_oe_o responds three to four clock cycles after an SCL edge. The bench holds each SCL phase for 10 clocks and changes SDA 2 clocks after a falling edge. It samples SDA in the middle of the high phase, long after any response has settled. A commit appears only once the busy period of WRITE_CYCLES has run out, so every write is followed by a wait longer than that period before the data is read back. The busy probe is placed a few hundred cycles after STOP, well inside the window.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } st_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/seeprom_bus_sampler.sv
module seeprom_bus_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/seeprom_write_timer.sv
module seeprom_write_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
  parameter int DEPTH = 256,
  parameter int PAGE  = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               buf_we_i,
  input  logic [$clog2(PAGE)-1:0]            buf_slot_i,
  input  logic [7:0]                         buf_data_i,
  input  logic                               buf_clr_i,
  input  logic                               commit_i,
  input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] page_i,
  input  logic [$clog2(DEPTH)-1:0]           rd_addr_i,
  output logic [7:0]                         rd_data_o,
  output logic                               pending_o
);
  localparam int PW = $clog2(DEPTH) - $clog2(PAGE);

  logic [7:0]      buf_q [PAGE];
  logic [PAGE-1:0] val_q;
  logic [7:0]      mem_w [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      for (int s = 0; s < PAGE; s++) buf_q[s] <= 8'h00;
    end else if (buf_clr_i || commit_i) begin
      val_q <= '0;
    end else if (buf_we_i) begin
      buf_q[buf_slot_i] <= buf_data_i;
      val_q[buf_slot_i] <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [7:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= 8'hFF;
      else if (commit_i && page_i == PW'(i / PAGE) && val_q[i % PAGE])
        word_q <= buf_q[i % PAGE];
    end
    assign mem_w[i] = word_q;
  end

  assign rd_data_o = mem_w[rd_addr_i];
  assign pending_o = |val_q;
endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
  import seeprom_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, pending, commit, buf_we, byte_done, addr_hit;
  logic [7:0] rd_data;

  st_e          st_q;
  logic [7:0]   sh_q, tx_q;
  logic [3:0]   bit_q;
  logic [AW-1:0] ptr_q;
  logic         oe_q, rd_q, hack_q;

  seeprom_bus_sampler u_smp (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  seeprom_write_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  seeprom_array #(.DEPTH(DEPTH), .PAGE(PAGE_BYTES)) u_arr (
    .clk_i, .rst_ni,
    .buf_we_i(buf_we), .buf_slot_i(ptr_q[SW-1:0]), .buf_data_i(sh_q),
    .buf_clr_i(start_evt), .commit_i(commit), .page_i(ptr_q[AW-1:SW]),
    .rd_addr_i(ptr_q), .rd_data_o(rd_data), .pending_o(pending)
  );

  assign byte_done = scl_fall && (bit_q == 4'd8);
  assign addr_hit  = (sh_q[7:1] == {DEV_TYPE, strap_i}) && !busy;
  assign buf_we    = (st_q == ST_WDATA) && byte_done && !wp_i;
  assign commit    = stop_evt && pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      tx_q   <= '0;
      bit_q  <= '0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      hack_q <= 1'b0;
    end else if (start_evt) begin
      st_q  <= ST_DEV;
      bit_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_evt) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_s};
            bit_q <= bit_q + 1'b1;
          end else if (byte_done) begin
            if (st_q == ST_DEV) begin
              if (addr_hit) begin
                oe_q <= 1'b1;
                rd_q <= sh_q[0];
                st_q <= ST_DEV_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end else if (st_q == ST_ADDR) begin
              ptr_q <= sh_q[AW-1:0];
              oe_q  <= 1'b1;
              st_q  <= ST_ADDR_ACK;
            end else begin
              ptr_q[SW-1:0] <= ptr_q[SW-1:0] + 1'b1;  // wrap inside page
              oe_q <= 1'b1;
              st_q <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              tx_q  <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr_q <= ptr_q + 1'b1;
              bit_q <= 4'd1;
              st_q  <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              bit_q <= '0;
              st_q  <= ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            bit_q <= '0;
            st_q  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_q <= 1'b0;
              st_q <= ST_RACK;
            end else begin
              oe_q  <= ~tx_q[6];
              tx_q  <= {tx_q[6:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) hack_q <= ~sda_s;
          else if (scl_fall) begin
            if (hack_q) begin
              tx_q  <= rd_data;
              oe_q  <= ~rd_data[7];
              ptr_q <= ptr_q + 1'b1;
              bit_q <= 4'd1;
              st_q  <= ST_RDATA;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/seeprom_target_chk.sv
module seeprom_target_chk
  import seeprom_pkg::*;
#(
  parameter int PW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          oe_i,
  input st_e           st_i,
  input logic          busy_i,
  input logic [PW-1:0] page_i
);
  AST_OE_HELD_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_s_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(oe_i)); // R12

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !oe_i); // R2

  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (st_i != ST_DEV_ACK)); // R7

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i)); // R4

  AST_PAGE_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_i == ST_WDATA || st_i == ST_WDATA_ACK) &&
     (st_i == ST_WDATA || st_i == ST_WDATA_ACK)) |-> $stable(page_i)); // R5
endmodule

bind seeprom_target seeprom_target_chk #(.PW(AW - SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_i(start_evt),
  .stop_i(stop_evt), .oe_i(sda_oe_o), .st_i(st_q), .busy_i(busy),
  .page_i(ptr_q[AW-1:SW])
);

// File: tb/seeprom_target_test.sv
`timescale 1ns/1ps
module seeprom_target_test;
  localparam int DEPTH = 256;
  localparam int WC    = 2000;
  localparam int H     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic oe;
  wire  bus_sda = sda_h & ~oe;

  always #2.5 clk = ~clk;

  seeprom_target #(.DEPTH(DEPTH), .PAGE_BYTES(8), .WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(bus_sda),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(oe)
  );

  logic [7:0] model [DEPTH];
  logic [7:0] wbuf [16];
  int mptr = 0;
  int errs = 0, checks = 0, stab_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, strap, rw};
  endfunction

  task automatic i2c_start();
    sda_h = 1'b0; cyc(H); scl_h = 1'b0; cyc(H);
  endtask

  task automatic i2c_rstart();
    cyc(2); sda_h = 1'b1; cyc(H); scl_h = 1'b1; cyc(H);
    sda_h = 1'b0; cyc(H); scl_h = 1'b0; cyc(H);
  endtask

  task automatic i2c_stop();
    cyc(2); sda_h = 1'b0; cyc(H - 2); scl_h = 1'b1; cyc(H); sda_h = 1'b1; cyc(H);
  endtask

  task automatic bit_out(input logic b);
    cyc(2); sda_h = b; cyc(H - 2); scl_h = 1'b1; cyc(H); scl_h = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    logic o1;
    cyc(2); sda_h = 1'b1; cyc(H - 2); scl_h = 1'b1;
    cyc(H / 2); b = bus_sda; o1 = oe;
    cyc(H / 2 - 1);
    if (oe !== o1) stab_err++;
    cyc(1); scl_h = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, input bit chk_rel, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = !a;
    if (ack && chk_rel) begin
      cyc(6);
      chk(oe == 1'b0, "R2 ack release", oe, 0);
    end
  endtask

  task automatic rbyte(input bit host_ack, output logic [7:0] d);
    logic b;
    stab_err = 0;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(!host_ack);
    chk(stab_err == 0, "R12 data stable while SCL high", stab_err, 0);
  endtask

  task automatic write_seq(input int addr, input int n, input bit wait_busy);
    bit ack;
    int base;
    base = addr & ~7;
    i2c_start();
    wbyte(dev(1'b0), 1'b1, ack); chk(ack, "R1 write address ack", ack, 1);
    wbyte(8'(addr), 1'b1, ack);
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], 1'b1, ack);
      chk(ack, wp ? "R8 data ack under protect" : "R4 data ack", ack, 1);
      if (!wp) model[base | ((addr + k) & 7)] = wbuf[k];
    end
    i2c_stop();
    mptr = base | ((addr + n) & 7);
    if (wait_busy && !wp && n > 0) cyc(WC + 40);
  endtask

  task automatic read_seq(input bit random, input int addr, input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start();
    if (random) begin
      wbyte(dev(1'b0), 1'b1, ack);
      wbyte(8'(addr), 1'b1, ack);
      i2c_rstart();
      mptr = addr;
    end
    wbyte(dev(1'b1), 1'b0, ack); chk(ack, "R1 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k < n - 1, d);
      chk(d == model[mptr], req, d, model[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ack;
    int seed, a, n;
    seed = $urandom(32'd4242);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    cyc(5); rst_n = 1'b1; cyc(5);
    chk(oe == 1'b0, "R3 released after reset", oe, 0);

    // R3 / R9: current-address read after reset hits word 0
    read_seq(1'b0, 0, 1, "R3 erased word at pointer 0");

    // R1: address mismatches
    i2c_start(); wbyte({4'b1010, 3'b100, 1'b0}, 1'b1, ack); i2c_stop();
    chk(!ack, "R1 strap mismatch nack", ack, 0);
    i2c_start(); wbyte({4'b1011, strap, 1'b0}, 1'b1, ack); i2c_stop();
    chk(!ack, "R1 type mismatch nack", ack, 0);

    // R4 / R10: full page then random read
    for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h30 + k);
    write_seq(8'h10, 8, 1'b1);
    read_seq(1'b1, 8'h10, 8, "R10 random read of page");

    // R7: busy window
    wbuf[0] = 8'hA5;
    write_seq(8'h20, 1, 1'b0);
    cyc(200);
    i2c_start(); wbyte(dev(1'b0), 1'b1, ack); i2c_stop();
    chk(!ack, "R7 nack during write cycle", ack, 0);
    cyc(WC);
    i2c_start(); wbyte(dev(1'b0), 1'b1, ack); i2c_stop();
    chk(ack, "R7 ack after write cycle", ack, 1);
    read_seq(1'b1, 8'h20, 1, "R4 byte write committed");

    // R5 / R9: 10 bytes wrap in page 0x18
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'hC0 + k);
    write_seq(8'h1E, 10, 1'b1);
    read_seq(1'b0, 0, 1, "R9 pointer after wrapped write");
    read_seq(1'b1, 8'h18, 8, "R5 page wrap overwrite");

    // R6: partial page
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    write_seq(8'h42, 2, 1'b1);
    read_seq(1'b1, 8'h40, 8, "R6 partial page neighbours");

    // R8: write protect
    wp = 1'b1;
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    write_seq(8'h11, 3, 1'b0);
    i2c_start(); wbyte(dev(1'b0), 1'b1, ack); i2c_stop();
    chk(ack, "R8 no busy under protect", ack, 1);
    wp = 1'b0;
    read_seq(1'b1, 8'h10, 4, "R8 array unchanged under protect");

    // R13: repeated start discards buffered data
    i2c_start();
    wbyte(dev(1'b0), 1'b1, ack);
    wbyte(8'h70, 1'b1, ack);
    wbyte(8'h5A, 1'b1, ack);
    i2c_rstart();
    wbyte(dev(1'b0), 1'b1, ack);
    wbyte(8'h70, 1'b1, ack);
    i2c_rstart();
    wbyte(dev(1'b1), 1'b0, ack);
    begin
      logic [7:0] d;
      rbyte(1'b0, d);
      chk(d == model[8'h70], "R13 aborted write discarded", d, model[8'h70]);
    end
    i2c_stop();

    // R11: rollover
    read_seq(1'b1, DEPTH - 2, 4, "R11 sequential rollover");

    // random writes checked by page read-back
    for (int it = 0; it < 8; it++) begin
      a = $urandom % DEPTH;
      n = 1 + ($urandom % 10);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      write_seq(a, n, 1'b1);
      read_seq(1'b1, a & ~7, 9, "R11 random page read-back");
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule